// File: doc/BRIEF.md
# Program/Erase Status Polling Engine

This block stands in for the busy timing of a flash memory's internal program/erase controller. A command decoder upstream hands it start requests (byte program with address and data, sector erase with a sector mask, whole-array erase, suspend, resume and a reset command). The engine runs a cycle counter for each operation. It signals when the array model should commit the result, and it answers every read strobe with either the array byte or a computed status byte.

While an operation runs, a read returns a status byte instead of array data. Bit 7 is a polarity flag: it holds the complement of the programmed data's bit 7, and it is 0 during an erase. Bit 6 inverts on each status read. Bit 5 reports a timeout. Bit 3 shows that the window for adding more erase sectors has closed. A running erase can be suspended, which lets reads of the sectors that are not being erased return array data, and it can later be resumed.

Read responses come one cycle after the strobe and cannot be stalled. Commands are single-cycle strobes. A strobe that is not meaningful in the current state is dropped without effect.

Top module: `pe_status_engine`

## Requirements
- R1: After reset the engine is idle: `busy`=0, `suspended`=0, no commit pulse, and the first status toggle value reported is 0.
- R2: Read responses: `rd_resp_valid` is high exactly one cycle after each `rd_valid`. When the engine is idle, or when it is suspended and the read sector is not in the erase set, `rd_resp_data` equals `arr_rdata` as sampled with the strobe. The sector index is the top log2(NSECT) bits of an address.
- R3: A program (`cmd_op`=1) to an unprotected sector with `verify_ok` high keeps `busy` high for exactly PROG_CYC cycles. It ends with a one-cycle `commit_prog` pulse, with `commit_addr`/`commit_data` equal to the request.
- R4: The status byte layout is {b7, toggle, error, 0, timer, 0, 0, 0}. During a program b7 = ~data[7] and timer = 0. During an erase b7 = 0.
- R5: Bit 6 inverts after every read that returns status while `busy` is high. It keeps its value across idle periods.
- R6: A sector erase (`cmd_op`=2) opens a window of WIN_CYC cycles, and timer=0 while the window is open. A further sector erase command inside the window ORs its mask into the erase set and restarts the window. After the window closes, timer=1, and the erase phase lasts ERASE_CYC cycles before a `commit_erase` pulse with `commit_mask` equal to the erase set.
- R7: A bulk erase (`cmd_op`=3) targets every unprotected sector. It skips the window, so timer=1 from the first cycle, and it lasts ERASE_CYC cycles.
- R8: Sectors set in `prot_mask` are removed from every erase set. A program to a protected sector, or an erase whose set becomes empty, keeps `busy` high for PROT_CYC cycles and produces no commit.
- R9: Suspend (`cmd_op`=4) is accepted in the window or in the erase phase. It sets `suspended`, clears `busy` and freezes the erase count; no commit occurs while suspended. Status reads of sectors in the erase set do not invert bit 6. Resume (`cmd_op`=5) continues the erase from the frozen count; after a suspend from the window, the erase phase starts from zero.
- R10: Completion needs `verify_ok` high once the duration has elapsed. If the busy count reaches TMO_CYC cycles first, the engine enters an error state with bit 5 = 1 and `busy` high, and it makes no commit. Only a reset command (`cmd_op`=0) returns it to idle.
- R11: While an operation runs, commands other than those named in R6, R9 and R10 are ignored and do not change its timing or committed values. Suspend and resume are ignored when idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 3 | 0 reset, 1 program, 2 sector erase, 3 bulk erase, 4 suspend, 5 resume |
| cmd_addr | input | ADDR_W | Program address |
| cmd_data | input | 8 | Program data |
| cmd_mask | input | NSECT | Sector erase mask |
| prot_mask | input | NSECT | Protected sectors |
| verify_ok | input | 1 | Array model reports the cells verified |
| rd_valid | input | 1 | Read strobe |
| rd_addr | input | ADDR_W | Read address |
| arr_rdata | input | 8 | Array byte for `rd_addr` |
| rd_resp_valid | output | 1 | Read response valid |
| rd_resp_data | output | 8 | Array data or status byte |
| busy | output | 1 | Operation running or in error |
| suspended | output | 1 | Erase suspended |
| commit_prog | output | 1 | Program commit pulse |
| commit_erase | output | 1 | Erase commit pulse |
| commit_addr | output | ADDR_W | Committed program address |
| commit_data | output | 8 | Committed program data |
| commit_mask | output | NSECT | Committed erase set |

## Verification
The bench builds the engine with an 8-bit address, four sectors and very short durations: PROG_CYC=5, WIN_CYC=4, ERASE_CYC=12, PROT_CYC=2 and TMO_CYC=20. With these values every protection mask can be crossed with every target sector and every erase mask, and every run stays a few dozen cycles long. The timeout, the window restart and a suspend part-way through an erase each fall on exact cycle counts that the bench derives from these parameters.

// File: rtl/pe_pkg.sv
package pe_pkg;
  typedef enum logic [2:0] {
    OP_RESET  = 3'd0,
    OP_PROG   = 3'd1,
    OP_SERASE = 3'd2,
    OP_BULK   = 3'd3,
    OP_SUSP   = 3'd4,
    OP_RESUME = 3'd5
  } pe_op_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_PROG, ST_PROT, ST_EWIN, ST_EBUSY, ST_SUSP, ST_ERR
  } pe_state_e;

  function automatic logic is_active(pe_state_e s);
    return (s == ST_PROG) || (s == ST_PROT) || (s == ST_EWIN) ||
           (s == ST_EBUSY) || (s == ST_ERR);
  endfunction
endpackage

// File: rtl/pe_cycle_timer.sv
module pe_cycle_timer #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          run,
  output logic [CW-1:0] cnt
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt <= '0;
    else if (clr) cnt <= '0;
    else if (run) cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/pe_sequencer.sv
module pe_sequencer
  import pe_pkg::*;
#(
  parameter int ADDR_W    = 19,
  parameter int NSECT     = 8,
  parameter int PROG_CYC  = 500,
  parameter int WIN_CYC   = 2500,
  parameter int ERASE_CYC = 75000,
  parameter int PROT_CYC  = 50,
  parameter int TMO_CYC   = 150000,
  parameter int CW        = 18
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [2:0]        cmd_op,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [7:0]        cmd_data,
  input  logic [NSECT-1:0]  cmd_mask,
  input  logic [NSECT-1:0]  prot_mask,
  input  logic              verify_ok,
  input  logic [CW-1:0]     cnt,
  output logic              cnt_clr,
  output logic              cnt_run,
  output pe_state_e         state,
  output logic              is_prog,
  output logic              pdata7,
  output logic [NSECT-1:0]  emask,
  output logic              commit_prog,
  output logic              commit_erase,
  output logic [ADDR_W-1:0] commit_addr,
  output logic [7:0]        commit_data,
  output logic [NSECT-1:0]  commit_mask
);
  localparam int SECT_W = $clog2(NSECT);
  localparam logic [CW-1:0] PROG_LAST  = CW'(PROG_CYC - 1);
  localparam logic [CW-1:0] WIN_LAST   = CW'(WIN_CYC - 1);
  localparam logic [CW-1:0] ERASE_LAST = CW'(ERASE_CYC - 1);
  localparam logic [CW-1:0] PROT_LAST  = CW'(PROT_CYC - 1);
  localparam logic [CW-1:0] TMO_LAST   = CW'(TMO_CYC - 1);

  pe_op_e            op;
  pe_state_e         st_nx;
  logic [SECT_W-1:0] cmd_sect;
  logic [NSECT-1:0]  req_set;
  logic              ld_prog, ld_erase, add_erase, do_cprog, do_cerase, clr_set;
  logic [ADDR_W-1:0] paddr;
  logic [7:0]        pdata;

  assign op       = pe_op_e'(cmd_op);
  assign cmd_sect = cmd_addr[ADDR_W-1 -: SECT_W];
  assign req_set  = ((op == OP_BULK) ? {NSECT{1'b1}} : cmd_mask) & ~prot_mask;
  assign pdata7   = pdata[7];

  always_comb begin
    st_nx = state; cnt_clr = 1'b0; cnt_run = 1'b0;
    ld_prog = 1'b0; ld_erase = 1'b0; add_erase = 1'b0;
    do_cprog = 1'b0; do_cerase = 1'b0; clr_set = 1'b0;
    unique case (state)
      ST_IDLE: if (cmd_valid) begin
        if (op == OP_PROG) begin
          cnt_clr = 1'b1; ld_prog = 1'b1;
          st_nx = prot_mask[cmd_sect] ? ST_PROT : ST_PROG;
        end else if (op == OP_SERASE || op == OP_BULK) begin
          cnt_clr = 1'b1; ld_erase = 1'b1;
          if (req_set == '0)       st_nx = ST_PROT;
          else if (op == OP_BULK)  st_nx = ST_EBUSY;
          else                     st_nx = ST_EWIN;
        end
      end
      ST_PROG: begin
        if (cnt >= PROG_LAST && verify_ok) begin st_nx = ST_IDLE; do_cprog = 1'b1; end
        else if (cnt == TMO_LAST)          st_nx = ST_ERR;
        else                               cnt_run = 1'b1;
      end
      ST_PROT: begin
        if (cnt == PROT_LAST) st_nx = ST_IDLE;
        else                  cnt_run = 1'b1;
      end
      ST_EWIN: begin
        if (cmd_valid && op == OP_SUSP)        begin st_nx = ST_SUSP; cnt_clr = 1'b1; end
        else if (cmd_valid && op == OP_SERASE) begin add_erase = 1'b1; cnt_clr = 1'b1; end
        else if (cnt == WIN_LAST)              begin st_nx = ST_EBUSY; cnt_clr = 1'b1; end
        else                                   cnt_run = 1'b1;
      end
      ST_EBUSY: begin
        if (cmd_valid && op == OP_SUSP)          st_nx = ST_SUSP;
        else if (cnt >= ERASE_LAST && verify_ok) begin
          st_nx = ST_IDLE; do_cerase = 1'b1; clr_set = 1'b1;
        end
        else if (cnt == TMO_LAST)                st_nx = ST_ERR;
        else                                     cnt_run = 1'b1;
      end
      ST_SUSP: if (cmd_valid && op == OP_RESUME) st_nx = ST_EBUSY;
      ST_ERR:  if (cmd_valid && op == OP_RESET) begin st_nx = ST_IDLE; clr_set = 1'b1; end
      default: st_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE; is_prog <= 1'b0; paddr <= '0; pdata <= '0; emask <= '0;
      commit_prog <= 1'b0; commit_erase <= 1'b0;
      commit_addr <= '0; commit_data <= '0; commit_mask <= '0;
    end else begin
      state        <= st_nx;
      commit_prog  <= do_cprog;
      commit_erase <= do_cerase;
      if (ld_prog) begin is_prog <= 1'b1; paddr <= cmd_addr; pdata <= cmd_data; end
      if (ld_erase) begin is_prog <= 1'b0; emask <= req_set; end
      else if (add_erase) emask <= emask | req_set;
      else if (clr_set)   emask <= '0;
      if (do_cprog) begin commit_addr <= paddr; commit_data <= pdata; end
      if (do_cerase) commit_mask <= emask;
    end
  end

  p_err_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_ERR && !(cmd_valid && op == OP_RESET)) |=> state == ST_ERR);
  p_susp_no_commit_r9: assert property (@(posedge clk) disable iff (!rst_n)
    state == ST_SUSP |=> !commit_erase);
  p_prot_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    state == ST_PROT |=> !(commit_prog || commit_erase));
  p_commit_nonempty_r8: assert property (@(posedge clk) disable iff (!rst_n)
    commit_erase |-> commit_mask != '0);
  p_commit_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({commit_prog, commit_erase}));
endmodule

// File: rtl/pe_status_fmt.sv
module pe_status_fmt
  import pe_pkg::*;
#(
  parameter int NSECT  = 8,
  parameter int SECT_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_valid,
  input  logic [SECT_W-1:0] rd_sect,
  input  logic [7:0]        arr_rdata,
  input  pe_state_e         state,
  input  logic              is_prog,
  input  logic              pdata7,
  input  logic [NSECT-1:0]  emask,
  output logic              rd_resp_valid,
  output logic [7:0]        rd_resp_data
);
  logic       active, show_status, tog, timer, err;
  logic [7:0] status;

  assign active      = is_active(state);
  assign show_status = active || (state == ST_SUSP && emask[rd_sect]);
  assign err         = (state == ST_ERR);
  assign timer       = !is_prog &&
                       (state == ST_EBUSY || state == ST_SUSP || state == ST_ERR);
  assign status      = {is_prog & ~pdata7, tog, err, 1'b0, timer, 3'b000};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tog <= 1'b0; rd_resp_valid <= 1'b0; rd_resp_data <= '0;
    end else begin
      rd_resp_valid <= rd_valid;
      if (rd_valid) rd_resp_data <= show_status ? status : arr_rdata;
      if (rd_valid && active) tog <= ~tog;
    end
  end

  p_tog_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_valid && active) |=> $stable(tog));
  p_resp_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> rd_resp_valid);
endmodule

// File: rtl/pe_status_engine.sv
module pe_status_engine
  import pe_pkg::*;
#(
  parameter int ADDR_W    = 19,
  parameter int NSECT     = 8,
  parameter int PROG_CYC  = 500,
  parameter int WIN_CYC   = 2500,
  parameter int ERASE_CYC = 75000,
  parameter int PROT_CYC  = 50,
  parameter int TMO_CYC   = 150000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [2:0]        cmd_op,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [7:0]        cmd_data,
  input  logic [NSECT-1:0]  cmd_mask,
  input  logic [NSECT-1:0]  prot_mask,
  input  logic              verify_ok,
  input  logic              rd_valid,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [7:0]        arr_rdata,
  output logic              rd_resp_valid,
  output logic [7:0]        rd_resp_data,
  output logic              busy,
  output logic              suspended,
  output logic              commit_prog,
  output logic              commit_erase,
  output logic [ADDR_W-1:0] commit_addr,
  output logic [7:0]        commit_data,
  output logic [NSECT-1:0]  commit_mask
);
  localparam int SECT_W = $clog2(NSECT);
  localparam int CW     = $clog2(TMO_CYC + 1);

  pe_state_e        state;
  logic [CW-1:0]    cnt;
  logic             cnt_clr, cnt_run, is_prog, pdata7;
  logic [NSECT-1:0] emask;
  logic             unused_addr_bits;

  assign unused_addr_bits = ^rd_addr[ADDR_W-SECT_W-1:0];
  assign busy      = is_active(state);
  assign suspended = (state == ST_SUSP);

  pe_cycle_timer #(.CW(CW)) u_timer (
    .clk(clk), .rst_n(rst_n), .clr(cnt_clr), .run(cnt_run), .cnt(cnt));

  pe_sequencer #(
    .ADDR_W(ADDR_W), .NSECT(NSECT), .PROG_CYC(PROG_CYC), .WIN_CYC(WIN_CYC),
    .ERASE_CYC(ERASE_CYC), .PROT_CYC(PROT_CYC), .TMO_CYC(TMO_CYC), .CW(CW)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_addr(cmd_addr), .cmd_data(cmd_data), .cmd_mask(cmd_mask),
    .prot_mask(prot_mask), .verify_ok(verify_ok), .cnt(cnt),
    .cnt_clr(cnt_clr), .cnt_run(cnt_run), .state(state), .is_prog(is_prog),
    .pdata7(pdata7), .emask(emask), .commit_prog(commit_prog),
    .commit_erase(commit_erase), .commit_addr(commit_addr),
    .commit_data(commit_data), .commit_mask(commit_mask));

  pe_status_fmt #(.NSECT(NSECT), .SECT_W(SECT_W)) u_fmt (
    .clk(clk), .rst_n(rst_n), .rd_valid(rd_valid),
    .rd_sect(rd_addr[ADDR_W-1 -: SECT_W]), .arr_rdata(arr_rdata),
    .state(state), .is_prog(is_prog), .pdata7(pdata7), .emask(emask),
    .rd_resp_valid(rd_resp_valid), .rd_resp_data(rd_resp_data));

  p_susp_not_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && suspended));
endmodule

// File: tb/tb_pe_status_engine.sv
`timescale 1ns/1ps
module tb_pe_status_engine;
  localparam int AW = 8, NS = 4, PC = 5, WC = 4, EC = 12, XC = 2, TC = 20;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_valid = 0, verify_ok = 1, rd_valid = 0;
  logic [2:0] cmd_op = 0;
  logic [AW-1:0] cmd_addr = 0, rd_addr = 0;
  logic [7:0] cmd_data = 0, arr_rdata;
  logic [NS-1:0] cmd_mask = 0, prot_mask = 0;
  logic rd_resp_valid, busy, suspended, commit_prog, commit_erase;
  logic [7:0] rd_resp_data, commit_data;
  logic [AW-1:0] commit_addr;
  logic [NS-1:0] commit_mask;

  int n_cmp = 0, n_bad = 0, n_cerase = 0;
  logic tog_exp = 1'b0;

  always #2.5 clk = ~clk;
  assign arr_rdata = rd_addr ^ 8'hA5;
  always @(negedge clk) if (commit_erase) n_cerase++;

  pe_status_engine #(.ADDR_W(AW), .NSECT(NS), .PROG_CYC(PC), .WIN_CYC(WC),
    .ERASE_CYC(EC), .PROT_CYC(XC), .TMO_CYC(TC)) dut (.*);

  task automatic chk(string tag, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cmd(logic [2:0] op, logic [AW-1:0] a, logic [7:0] d, logic [NS-1:0] m);
    cmd_valid = 1; cmd_op = op; cmd_addr = a; cmd_data = d; cmd_mask = m;
    @(negedge clk); cmd_valid = 0;
  endtask

  task automatic rd(logic [AW-1:0] a, output logic [7:0] d);
    rd_valid = 1; rd_addr = a;
    @(negedge clk); rd_valid = 0;
    chk("R2 resp valid", rd_resp_valid, 1);
    d = rd_resp_data;
  endtask

  // status read while busy: compares with expected toggle, then flips it
  task automatic rd_stat(string tag, logic [AW-1:0] a, logic [7:0] base);
    logic [7:0] d;
    rd(a, d);
    chk(tag, d, base | {1'b0, tog_exp, 6'b0});
    tog_exp = ~tog_exp;
  endtask

  task automatic wait_idle(output int n);
    n = 0;
    while (busy && n < 200) begin @(negedge clk); n++; end
  endtask

  task automatic waitn(int k);
    for (int i = 0; i < k; i++) @(negedge clk);
  endtask

  initial begin
    #1000000;
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [7:0] d;
    int n, eff;
    waitn(2); rst_n = 1; waitn(1);
    // R1 reset state
    chk("R1 busy", busy, 0);
    chk("R1 suspended", suspended, 0);
    chk("R1 commits", {commit_prog, commit_erase}, 0);
    rd(8'h3C, d); chk("R2 idle array", d, 8'h3C ^ 8'hA5);

    // R3 R4 R5 program status per sector and data polarity
    for (int s = 0; s < NS; s++)
      for (int b = 0; b < 2; b++) begin
        logic [7:0] pd;
        logic [AW-1:0] pa;
        pd = {b[0], 7'h2A}; pa = {s[1:0], 6'h15};
        cmd(3'd1, pa, pd, 0);
        for (int k = 0; k < PC; k++) rd_stat("R4 R5 prog status", pa, {~pd[7], 7'b0});
        chk("R3 prog done", busy, 0);
        chk("R3 commit pulse", commit_prog, 1);
        chk("R3 commit addr", commit_addr, pa);
        chk("R3 commit data", commit_data, pd);
        rd(pa, d); chk("R2 data after program", d, pa ^ 8'hA5);
      end
    cmd(3'd1, 8'h01, 8'h00, 0); wait_idle(n); chk("R3 prog cycles", n, PC);

    // R8 program protection sweep
    for (int p = 0; p < 16; p++)
      for (int s = 0; s < NS; s++) begin
        prot_mask = p[3:0];
        cmd(3'd1, {s[1:0], 6'h07}, 8'h5A, 0);
        wait_idle(n);
        chk("R8 prog prot cycles", n, p[s] ? XC : PC);
        chk("R8 prog prot commit", commit_prog, p[s] ? 0 : 1);
      end

    // R6 R8 sector erase sweep over protection and mask
    for (int p = 0; p < 16; p++)
      for (int m = 1; m < 16; m++) begin
        prot_mask = p[3:0];
        eff = m & ~p & 15;
        cmd(3'd2, 0, 0, m[3:0]);
        wait_idle(n);
        chk("R6 R8 erase cycles", n, (eff != 0) ? WC + EC : XC);
        chk("R8 erase commit", commit_erase, (eff != 0) ? 1 : 0);
        if (eff != 0) chk("R8 erase set", commit_mask, eff);
      end

    // R7 bulk erase sweep
    for (int p = 0; p < 16; p++) begin
      prot_mask = p[3:0];
      eff = ~p & 15;
      cmd(3'd3, 0, 0, 0);
      wait_idle(n);
      chk("R7 bulk cycles", n, (eff != 0) ? EC : XC);
      if (eff != 0) chk("R7 bulk set", commit_mask, eff);
    end
    prot_mask = 0;
    cmd(3'd3, 0, 0, 0);
    rd_stat("R7 bulk timer at start", 8'h00, 8'h08);
    wait_idle(n); chk("R7 bulk rest", n, EC - 1);

    // R6 window: timer low, restart by extra sector
    cmd(3'd2, 0, 0, 4'b0001);
    rd_stat("R6 window timer low", 8'h00, 8'h00);
    waitn(1);
    cmd(3'd2, 0, 0, 4'b0100);
    wait_idle(n);
    chk("R6 window restart cycles", n, WC + EC);
    chk("R6 merged set", commit_mask, 4'b0101);
    cmd(3'd2, 0, 0, 4'b0010);
    waitn(WC);
    rd_stat("R6 timer after window", 8'h40, 8'h08);
    wait_idle(n); chk("R6 erase rest", n, EC - 1);

    // R9 suspend in erase phase
    cmd(3'd2, 0, 0, 4'b0001);
    waitn(WC + 3);
    cmd(3'd4, 0, 0, 0);
    chk("R9 suspended", suspended, 1);
    chk("R9 not busy", busy, 0);
    rd(8'h45, d); chk("R2 R9 other sector array", d, 8'h45 ^ 8'hA5);
    rd(8'h05, d); chk("R9 held status a", d, {1'b0, tog_exp, 6'b001000});
    rd(8'h05, d); chk("R9 held status b", d, {1'b0, tog_exp, 6'b001000});
    n = n_cerase; waitn(10);
    chk("R9 no commit while suspended", n_cerase, n);
    cmd(3'd5, 0, 0, 0);
    wait_idle(n);
    chk("R9 resume remaining", n, EC - 3);
    chk("R9 resume commit", commit_mask, 4'b0001);
    // R9 suspend inside window
    cmd(3'd2, 0, 0, 4'b1000);
    cmd(3'd4, 0, 0, 0);
    chk("R9 window suspend", suspended, 1);
    cmd(3'd5, 0, 0, 0);
    wait_idle(n); chk("R9 window resume cycles", n, EC);

    // R10 timeout on program
    verify_ok = 0;
    cmd(3'd1, 8'h80, 8'h00, 0);
    waitn(TC - 1);
    rd_stat("R10 before timeout", 8'h80, 8'h80);
    rd_stat("R10 program error", 8'h80, 8'hA0);
    waitn(5);
    chk("R10 stays busy", busy, 1);
    verify_ok = 1; waitn(2);
    rd_stat("R10 verify ignored", 8'h80, 8'hA0);
    cmd(3'd0, 0, 0, 0);
    chk("R10 reset clears", busy, 0);
    rd(8'h80, d); chk("R10 array after reset", d, 8'h80 ^ 8'hA5);
    // R10 timeout on erase
    verify_ok = 0;
    cmd(3'd3, 0, 0, 0);
    waitn(TC);
    rd_stat("R10 erase error", 8'h00, 8'h28);
    cmd(3'd0, 0, 0, 0);
    chk("R10 erase reset", busy, 0);
    // R10 late verify
    cmd(3'd1, 8'h11, 8'h22, 0);
    waitn(8); verify_ok = 1;
    wait_idle(n); chk("R10 late verify", n, 1);
    chk("R10 late commit", commit_prog, 1);

    // R11 ignored commands
    cmd(3'd1, 8'hC3, 8'h99, 0);
    cmd(3'd1, 8'h0F, 8'h11, 0);
    cmd(3'd0, 0, 0, 0);
    cmd(3'd4, 0, 0, 0);
    wait_idle(n);
    chk("R11 timing unchanged", n, PC - 3);
    chk("R11 addr unchanged", commit_addr, 8'hC3);
    chk("R11 data unchanged", commit_data, 8'h99);
    cmd(3'd4, 0, 0, 0);
    chk("R11 idle suspend ignored", suspended, 0);
    cmd(3'd5, 0, 0, 0);
    chk("R11 idle resume ignored", busy, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule